// File: doc/BRIEF.md
# Down-Counting Timer with Two Match Thresholds

This block is a single timer channel. Once enabled, it counts down from a programmable reload value, stepping once per selected tick strobe. When the count reaches zero, the next tick restarts it from the reload value. Two match thresholds can be written in either order. An interrupt event occurs when a decrement lands on either threshold, and also when the count reaches zero if the overflow-interrupt control is set or either threshold is zero. Each event inverts a level interrupt line rather than pulsing it, so the interrupt consumer detects events by watching for a change of level.

Two tick strobes arrive from outside: a slow external-rate strobe (nominally 1 MHz) and a fast bus-rate strobe (nominally 24 MHz). A source-select control bit chooses between them. Software can load the live count, the reload value and both thresholds through separate write strobes. The live count is always visible on an output.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the count, the reload value, both thresholds and the interrupt level are zero. If the timer is enabled with no reload written, its count is 0.
- R2: At the clock edge where enable is first sampled high, the count loads the reload value. After that, each sampled tick lowers a non-zero count by one at that same edge.
- R3: A tick sampled while the count is zero reloads the count from the reload value. If the reload value is zero, the count stays at zero and no events occur.
- R4: A decrement that lands on a non-zero threshold value inverts the interrupt level. Both thresholds fire once per period, and swapping the two values does not change the result.
- R5: A decrement that reaches zero inverts the interrupt level only when overflow-interrupt enable is 1 or at least one threshold is zero.
- R6: A single tick inverts the interrupt level at most once, even when both thresholds are equal. Reload steps, enable and count writes never invert it.
- R7: When source select is 0, the fast strobe is the tick. When it is 1, the slow strobe is the tick. The strobe that is not selected has no effect.
- R8: A count write while enabled loads the written value, and counting continues from it. The write takes priority over a tick in the same cycle. An enable edge takes priority over the write.
- R9: While enable is low, the count holds, count writes are ignored and the interrupt level does not change. Reload and threshold writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_slow_i | input | 1 | Slow external-rate tick strobe |
| tick_fast_i | input | 1 | Fast bus-rate tick strobe |
| en_i | input | 1 | Channel enable |
| clk_sel_i | input | 1 | Tick source select: 0 fast, 1 slow |
| ovf_irq_en_i | input | 1 | Event on reaching zero |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write value |
| reload_we_i | input | 1 | Reload write strobe |
| reload_wdata_i | input | CNT_W | Reload write value |
| match_a_we_i | input | 1 | First threshold write strobe |
| match_a_wdata_i | input | CNT_W | First threshold value |
| match_b_we_i | input | 1 | Second threshold write strobe |
| match_b_wdata_i | input | CNT_W | Second threshold value |
| count_o | output | CNT_W | Live count |
| irq_o | output | 1 | Interrupt level, inverted per event |

## Verification
The count and the interrupt level are both registered, so a wrong next-count choice shows on count_o at the edge after the offending tick. Every later period then starts from the wrong value. A missed or doubled event is more subtle: the level stays flipped until the next event, which can be a whole period later. For that reason, comparing the output against a reference every cycle catches it at the edge where it happens. Per-period toggle counts also catch it. Threshold order, zero thresholds and the zero-reload stop are exercised with directed sequences before the random traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_pkg::*;
(
  input  logic src_i,
  input  logic slow_i,
  input  logic fast_i,
  output logic tick_o
);
  tick_src_e src;
  always_comb begin
    src    = tick_src_e'(src_i);
    tick_o = (src == SRC_SLOW) ? slow_i : fast_i;
  end
endmodule

// File: rtl/tmr_match_sort.sv
module tmr_match_sort #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic a_ge_b;
  always_comb begin
    a_ge_b = (a_i >= b_i);
    hi_o   = a_ge_b ? a_i : b_i;
    lo_o   = a_ge_b ? b_i : a_i;
  end
endmodule

// File: rtl/tmr_evt.sv
module tmr_evt #(
  parameter int unsigned W = 16
) (
  input  logic         dec_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic         ovf_en_i,
  output logic         evt_o
);
  logic at_zero, zero_arm, hit;
  always_comb begin
    at_zero  = (nxt_i == '0);
    zero_arm = ovf_en_i || (lo_i == '0);   // lo is zero if either threshold is
    hit      = (nxt_i == hi_i) || (nxt_i == lo_i);
    evt_o    = dec_i && (at_zero ? zero_arm : hit);
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             en_i,
  input  logic             clk_sel_i,
  input  logic             ovf_irq_en_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             reload_we_i,
  input  logic [CNT_W-1:0] reload_wdata_i,
  input  logic             match_a_we_i,
  input  logic [CNT_W-1:0] match_a_wdata_i,
  input  logic             match_b_we_i,
  input  logic [CNT_W-1:0] match_b_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] count_q, reload_q, ma_q, mb_q, hi_w, lo_w, nxt_w;
  logic irq_q, en_q, tick_w, en_rise, run, dec, evt_w;

  tmr_tick_sel u_sel (
    .src_i (clk_sel_i),
    .slow_i(tick_slow_i),
    .fast_i(tick_fast_i),
    .tick_o(tick_w)
  );

  tmr_match_sort #(.W(CNT_W)) u_sort (
    .a_i (ma_q),
    .b_i (mb_q),
    .hi_o(hi_w),
    .lo_o(lo_w)
  );

  assign en_rise = en_i & ~en_q;
  assign run     = en_i & en_q & ~cnt_we_i & tick_w;
  assign dec     = run & (count_q != '0);
  assign nxt_w   = count_q - 1'b1;

  tmr_evt #(.W(CNT_W)) u_evt (
    .dec_i   (dec),
    .nxt_i   (nxt_w),
    .hi_i    (hi_w),
    .lo_i    (lo_w),
    .ovf_en_i(ovf_irq_en_i),
    .evt_o   (evt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
      ma_q     <= '0;
      mb_q     <= '0;
      irq_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= en_i;
      if (reload_we_i)  reload_q <= reload_wdata_i;
      if (match_a_we_i) ma_q     <= match_a_wdata_i;
      if (match_b_we_i) mb_q     <= match_b_wdata_i;
      if (en_rise)                count_q <= reload_q;
      else if (en_i && cnt_we_i)  count_q <= cnt_wdata_i;
      else if (dec)               count_q <= nxt_w;
      else if (run)               count_q <= reload_q;   // wrap at zero
      if (evt_w) irq_q <= ~irq_q;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;

  assert_enable_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !en_q) |=> (count_q == $past(reload_q)));

  assert_decrement_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !cnt_we_i && tick_w && count_q != '0)
      |=> ((count_q + 1'b1) == $past(count_q)));

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !cnt_we_i && tick_w && count_q == '0)
      |=> ((count_q == $past(reload_q)) && $stable(irq_q)));

  assert_irq_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tick_w) |=> $stable(irq_q));

  assert_count_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && cnt_we_i) |=> (count_q == $past(cnt_wdata_i)));

  assert_hold_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(count_q) && $stable(irq_q)));
endmodule

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb;
  localparam int W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slow = 0, fast = 0, en = 0, sel = 0, ovf = 0;
  logic cwe = 0, rwe = 0, awe = 0, bwe = 0;
  logic [W-1:0] cdat = '0, rdat = '0, adat = '0, bdat = '0;
  logic [W-1:0] count_o;
  logic irq_o;

  int total = 0, bad = 0, tog_cnt = 0;
  logic [W-1:0] m_cnt = '0, m_rel = '0, m_ma = '0, m_mb = '0;
  logic m_irq = 0, m_en = 0, last_irq = 0;

  always #4 clk_i = ~clk_i;

  dual_match_timer #(.CNT_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_slow_i(slow), .tick_fast_i(fast),
    .en_i(en), .clk_sel_i(sel), .ovf_irq_en_i(ovf),
    .cnt_we_i(cwe), .cnt_wdata_i(cdat),
    .reload_we_i(rwe), .reload_wdata_i(rdat),
    .match_a_we_i(awe), .match_a_wdata_i(adat),
    .match_b_we_i(bwe), .match_b_wdata_i(bdat),
    .count_o(count_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: model next state from requirements, compare after the edge
  task automatic step(input string req);
    logic [W-1:0] n_cnt;
    logic tick, tog;
    tick  = sel ? slow : fast;
    n_cnt = m_cnt;
    tog   = 1'b0;
    if (en && !m_en) n_cnt = m_rel;
    else if (en && cwe) n_cnt = cdat;
    else if (en && tick) begin
      if (m_cnt != '0) begin
        n_cnt = m_cnt - 1'b1;
        if (n_cnt == '0) tog = ovf || (m_ma == '0) || (m_mb == '0);
        else             tog = (n_cnt == m_ma) || (n_cnt == m_mb);
      end else n_cnt = m_rel;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    m_cnt = n_cnt;
    m_irq = m_irq ^ tog;
    if (rwe) m_rel = rdat;
    if (awe) m_ma = adat;
    if (bwe) m_mb = bdat;
    m_en = en;
    chk(count_o == m_cnt, {req, " count"}, count_o, m_cnt);
    chk(irq_o == m_irq, {req, " irq"}, irq_o, m_irq);
    if (irq_o != last_irq) tog_cnt++;
    last_irq = irq_o;
    cwe = 0; rwe = 0; awe = 0; bwe = 0;
  endtask

  task automatic run_fast(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      fast = 1'b1;
      step(req);
    end
    fast = 1'b0;
  endtask

  task automatic set_matches(input int a, input int b, input string req);
    awe = 1; adat = W'(a); bwe = 1; bdat = W'(b);
    step(req);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(count_o == 0, "R1 reset count", count_o, 0);
    chk(irq_o == 0, "R1 reset irq", irq_o, 0);
    en = 1; step("R1");
    chk(count_o == 0, "R1 reload reset value", count_o, 0);
    run_fast(3, "R3");                             // zero reload: stays at zero
    chk(count_o == 0 && irq_o == 0, "R3 zero reload hold", count_o, 0);
    en = 0; step("R9");

    rwe = 1; rdat = 10; set_matches(3, 7, "R9");  // accepted while disabled
    en = 1; step("R2");
    chk(count_o == 10, "R2 enable loads reload", count_o, 10);
    tog_cnt = 0; run_fast(10, "R4");
    chk(tog_cnt == 2, "R4 both thresholds fire", tog_cnt, 2);
    tog_cnt = 0; run_fast(1, "R3");
    chk(count_o == 10 && tog_cnt == 0, "R3 wrap to reload", count_o, 10);

    set_matches(7, 3, "R4");
    tog_cnt = 0; run_fast(10, "R4");
    chk(tog_cnt == 2, "R4 swapped order", tog_cnt, 2);

    ovf = 1; tog_cnt = 0; run_fast(11, "R5");
    chk(tog_cnt == 3, "R5 overflow event", tog_cnt, 3);
    ovf = 0; set_matches(0, 3, "R5");
    tog_cnt = 0; run_fast(11, "R5");
    chk(tog_cnt == 2, "R5 zero threshold forces event", tog_cnt, 2);
    set_matches(5, 5, "R6");
    tog_cnt = 0; run_fast(11, "R6");
    chk(tog_cnt == 1, "R6 equal thresholds one toggle", tog_cnt, 1);

    held = count_o;
    sel = 0; slow = 1;
    repeat (3) step("R7");
    chk(count_o == held, "R7 slow ignored on fast select", count_o, held);
    sel = 1;
    step("R7"); step("R7");
    chk(count_o == 9, "R7 slow strobe counts", count_o, 9);
    slow = 0; fast = 1; step("R7"); fast = 0;
    chk(count_o == 9, "R7 fast ignored on slow select", count_o, 9);
    sel = 0;

    fast = 1; cwe = 1; cdat = 4; step("R8");
    chk(count_o == 4, "R8 write beats tick", count_o, 4);
    step("R8"); fast = 0;
    chk(count_o == 3, "R8 continues from written value", count_o, 3);

    held = count_o; last_irq = irq_o;
    en = 0; fast = 1; cwe = 1; cdat = 2; ovf = 1; step("R9");
    chk(count_o == held, "R9 write ignored when disabled", count_o, held);
    run_fast(4, "R9");
    chk(count_o == held, "R9 ticks ignored when disabled", count_o, held);
    rwe = 1; rdat = 6; step("R9");
    en = 1; cwe = 1; cdat = 1; step("R8");
    chk(count_o == 6, "R8 enable edge beats write", count_o, 6);

    rwe = 1; rdat = 0; cwe = 1; cdat = 2; step("R3");
    tog_cnt = 0; run_fast(6, "R3");
    chk(count_o == 0 && tog_cnt == 1, "R3 stop at zero reload", tog_cnt, 1);
    ovf = 0;

    for (int i = 0; i < 5000; i++) begin
      if ($urandom % 50 == 0) en = ~en;
      if ($urandom % 100 == 0) sel = ~sel;
      if ($urandom % 100 == 0) ovf = ~ovf;
      fast = ($urandom % 2) == 0;
      slow = ($urandom % 5) == 0;
      if ($urandom % 40 == 0) begin cwe = 1; cdat = W'($urandom % 20); end
      if ($urandom % 40 == 0) begin rwe = 1; rdat = W'($urandom % 20); end
      if ($urandom % 40 == 0) begin awe = 1; adat = W'($urandom % 20); end
      if ($urandom % 40 == 0) begin bwe = 1; bdat = W'($urandom % 20); end
      step("R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule